// File: doc/BRIEF.md
# Transmit Path Reset and Power-Down Sequencer

This block runs from the always-on reference clock. It decides when the clocks of a transmit data path may run and when that path can be trusted with data. It filters the active-low hardware reset pin, so that only a low of qualifying length starts a reset. After reset is released it brings the master-clock enable up after a fixed delay and emits a one-cycle pulse that loads register defaults. Two control bits are written through a simple register write port: a software reset and a software transmit power-down.

Transmit power-down comes from the pin or from the software bit, and either one is enough. While it is active, the transmit clock enable is off and the CIC filter reset is held. When power-down is released, the transmit clock restarts at once. The CIC reset stays on for a fixed count of further cycles so that the upstream filters flush with fresh data. The transmit-ready flag combines sequencing state, power-down and the PLL lock flag. It falls in the same cycle as any of them.

Top module: `txpd_sequencer`

## Requirements
- R1: A reset-pin low lasting fewer than MIN_LOW_CYCLES (10) sampled clock edges is ignored. A low lasting 10 or more edges starts a hardware reset, and the sequencing state enters reset on the following edge.
- R2: While a reset (hardware or software) is in progress, the master-clock enable, the transmit clock enable and transmit-ready are all low, and the CIC reset is high.
- R3: Take the first clock edge that samples the reset pin high after a qualified reset. The master-clock enable goes high after the third edge following it (MCLK_DELAY = 3) and not before.
- R4: The register-defaults load pulse is high for exactly one cycle, two edges before the master-clock enable rises. At that pulse the software power-down bit returns to its default of 0.
- R5: Writing a word with bit 5 set to address 0x00, with the last-bit strobe high, starts a software reset. The master-clock enable drops after the next edge and rises again four edges after the write.
- R6: The software reset bit clears itself when the sequence finishes, so a single write produces exactly one reset sequence.
- R7: A low power-down pin turns off the transmit clock enable and raises the CIC reset combinationally, in the same cycle.
- R8: Bit 5 of address 0x02 is the software power-down. Its value is taken on the edge that samples the last-bit strobe. Writes to any other address leave power-down unchanged.
- R9: Pin and software power-down combine by OR. Power-down stays active while either source is active.
- R10: Once power-down is released, the transmit clock enable is high at once. The CIC reset stays high for exactly 80 more cycles (CIC_HOLD_CYCLES), and the same hold follows release from reset.
- R11: Transmit-ready is high only when the sequence is running, power-down is inactive and the PLL lock flag is high. A loss of lock lowers it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Always-running reference clock |
| rst_pin_n | input | 1 | Hardware reset pin, active low, filtered for length |
| pd_pin_n | input | 1 | Transmit power-down pin, active low |
| pll_lock_i | input | 1 | PLL frequency-lock flag |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| wr_last_i | input | 1 | Strobe marking the final bit of a register write |
| mclk_en_o | output | 1 | Master-clock enable |
| tx_clk_en_o | output | 1 | Transmit data path clock enable |
| cic_rst_o | output | 1 | CIC filter reset, active high |
| regs_load_o | output | 1 | One-cycle pulse loading register defaults |
| tx_ready_o | output | 1 | Transmit path ready for data |

## Verification
Reset lows of 9 and 10 edges tell a glitch apart from a real reset at the exact threshold. An edge-by-edge walk after release pins the three-cycle enable delay and the position of the load pulse. Power-down is applied three ways: from the pin alone, from the software bit alone, and from both at once, with one source then released. These cases separate the OR combination from either single source, and counting the CIC hold at cycles 80 and 81 exposes an off-by-one. A software reset issued with software power-down set shows that the sequence runs once and that the power-down bit returns to default. A write to an unrelated address and toggling of the lock flag confirm what must not change and what must drop at once.

// File: rtl/txseq_pkg.sv
package txseq_pkg;

    typedef enum logic [1:0] {
        SEQ_RST  = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/txseq_rst_filter.sv
module txseq_rst_filter #(
    parameter int MIN_LOW = 10
) (
    input  logic clk_ref,
    input  logic rst_pin_n,
    output logic hw_rst_o
);
    localparam int CW = $clog2(MIN_LOW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          active;
    } filt_t;

    filt_t filt_d, filt_q;

    always_comb begin
        filt_d = filt_q;
        if (rst_pin_n) begin
            filt_d.cnt    = '0;
            filt_d.active = 1'b0;
        end else begin
            if (filt_q.cnt != CW'(MIN_LOW))
                filt_d.cnt = filt_q.cnt + 1'b1;
            filt_d.active = filt_q.active || (filt_q.cnt == CW'(MIN_LOW - 1));
        end
    end

    always_ff @(posedge clk_ref) begin
        filt_q <= filt_d;
    end

    assign hw_rst_o = filt_q.active;

    // R1
    pin_high_clears_chk: assert property (@(posedge clk_ref)
        rst_pin_n |=> !hw_rst_o);

    // R1
    rise_needs_low_pin_chk: assert property (@(posedge clk_ref)
        $rose(hw_rst_o) |-> $past(!rst_pin_n));

endmodule

// File: rtl/txseq_ctrl_regs.sv
module txseq_ctrl_regs #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int RST_ADDR = 0,
    parameter int RST_BIT  = 5,
    parameter int PD_ADDR  = 2,
    parameter int PD_BIT   = 5
) (
    input  logic          clk_ref,
    input  logic          hw_rst_i,
    input  logic          load_i,
    input  logic          seq_done_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          wr_last_i,
    output logic          sw_rst_o,
    output logic          sw_pd_o
);
    typedef struct packed {
        logic sw_rst;
        logic sw_pd;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (hw_rst_i) begin
            ctrl_d = '0;
        end else begin
            if (load_i)
                ctrl_d.sw_pd = 1'b0;
            if (seq_done_i)
                ctrl_d.sw_rst = 1'b0;
            if (wr_last_i) begin
                if (wr_addr_i == AW'(RST_ADDR) && wr_data_i[RST_BIT])
                    ctrl_d.sw_rst = 1'b1;
                if (wr_addr_i == AW'(PD_ADDR))
                    ctrl_d.sw_pd = wr_data_i[PD_BIT];
            end
        end
    end

    always_ff @(posedge clk_ref) begin
        ctrl_q <= ctrl_d;
    end

    assign sw_rst_o = ctrl_q.sw_rst;
    assign sw_pd_o  = ctrl_q.sw_pd;

    // R8
    pd_write_lands_chk: assert property (@(posedge clk_ref) disable iff (hw_rst_i)
        (wr_last_i && wr_addr_i == AW'(PD_ADDR) && !hw_rst_i)
            |=> (sw_pd_o == $past(wr_data_i[PD_BIT])));

endmodule

// File: rtl/txseq_cic_hold.sv
module txseq_cic_hold #(
    parameter int HOLD = 80
) (
    input  logic clk_ref,
    input  logic hold_i,
    output logic cic_rst_o
);
    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  busy;

    always_comb begin
        hold_d = hold_q;
        if (hold_i)
            hold_d.cnt = HW'(HOLD);
        else if (hold_q.cnt != '0)
            hold_d.cnt = hold_q.cnt - 1'b1;
    end

    always_ff @(posedge clk_ref) begin
        hold_q <= hold_d;
    end

    assign busy      = (hold_q.cnt != '0);
    assign cic_rst_o = hold_i | busy;

    // R10
    release_keeps_cic_chk: assert property (@(posedge clk_ref)
        $fell(hold_i) |-> cic_rst_o);

    // R10
    hold_counts_down_chk: assert property (@(posedge clk_ref)
        (!hold_i && busy) |=> (hold_i || hold_q.cnt == $past(hold_q.cnt) - 1'b1));

endmodule

// File: rtl/txpd_sequencer.sv
module txpd_sequencer
    import txseq_pkg::*;
#(
    parameter int MIN_LOW_CYCLES  = 10,
    parameter int MCLK_DELAY      = 3,
    parameter int CIC_HOLD_CYCLES = 80,
    parameter int REG_AW          = 8,
    parameter int REG_DW          = 8,
    parameter int SWRST_ADDR      = 0,
    parameter int SWRST_BIT       = 5,
    parameter int SWPD_ADDR       = 2,
    parameter int SWPD_BIT        = 5
) (
    input  logic              clk_ref,
    input  logic              rst_pin_n,
    input  logic              pd_pin_n,
    input  logic              pll_lock_i,
    input  logic [REG_AW-1:0] wr_addr_i,
    input  logic [REG_DW-1:0] wr_data_i,
    input  logic              wr_last_i,
    output logic              mclk_en_o,
    output logic              tx_clk_en_o,
    output logic              cic_rst_o,
    output logic              regs_load_o,
    output logic              tx_ready_o
);
    localparam int DCW = $clog2(MCLK_DELAY + 1);

    typedef struct packed {
        seq_state_e     state;
        logic [DCW-1:0] wcnt;
        logic           load;
    } seq_t;

    seq_t seq_d, seq_q;
    logic hw_rst;
    logic sw_rst;
    logic sw_pd;
    logic seq_done;
    logic pd_any;
    logic run;

    txseq_rst_filter #(.MIN_LOW(MIN_LOW_CYCLES)) u_filter (
        .clk_ref   (clk_ref),
        .rst_pin_n (rst_pin_n),
        .hw_rst_o  (hw_rst)
    );

    assign seq_done = (seq_q.state == SEQ_WAIT) && (seq_q.wcnt == DCW'(MCLK_DELAY - 1));

    txseq_ctrl_regs #(
        .AW(REG_AW), .DW(REG_DW),
        .RST_ADDR(SWRST_ADDR), .RST_BIT(SWRST_BIT),
        .PD_ADDR(SWPD_ADDR), .PD_BIT(SWPD_BIT)
    ) u_regs (
        .clk_ref    (clk_ref),
        .hw_rst_i   (hw_rst),
        .load_i     (seq_q.load),
        .seq_done_i (seq_done),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .wr_last_i  (wr_last_i),
        .sw_rst_o   (sw_rst),
        .sw_pd_o    (sw_pd)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.load = 1'b0;
        unique case (seq_q.state)
            SEQ_RST: begin
                seq_d.state = SEQ_WAIT;
                seq_d.wcnt  = DCW'(1);
                seq_d.load  = 1'b1;
            end
            SEQ_WAIT: begin
                if (seq_done)
                    seq_d.state = SEQ_RUN;
                else
                    seq_d.wcnt = seq_q.wcnt + 1'b1;
            end
            SEQ_RUN: begin
                if (sw_rst)
                    seq_d.state = SEQ_RST;
            end
            default: seq_d.state = SEQ_RST;
        endcase
        if (hw_rst) begin
            seq_d.state = SEQ_RST;
            seq_d.wcnt  = '0;
            seq_d.load  = 1'b0;
        end
    end

    always_ff @(posedge clk_ref) begin
        seq_q <= seq_d;
    end

    assign run    = (seq_q.state == SEQ_RUN);
    assign pd_any = !pd_pin_n || sw_pd;

    txseq_cic_hold #(.HOLD(CIC_HOLD_CYCLES)) u_hold (
        .clk_ref   (clk_ref),
        .hold_i    (pd_any || !run),
        .cic_rst_o (cic_rst_o)
    );

    assign mclk_en_o   = run;
    assign tx_clk_en_o = run && !pd_any;
    assign regs_load_o = seq_q.load;
    assign tx_ready_o  = run && !pd_any && pll_lock_i;

    // R2
    hw_rst_stops_mclk_chk: assert property (@(posedge clk_ref)
        hw_rst |=> !mclk_en_o);

    // R3 R4
    load_precedes_mclk_chk: assert property (@(posedge clk_ref) disable iff (hw_rst)
        $rose(mclk_en_o) |-> $past(regs_load_o, 2));

    // R6
    swrst_cleared_at_run_chk: assert property (@(posedge clk_ref) disable iff (hw_rst)
        $rose(mclk_en_o) |-> !sw_rst);

    // R11
    ready_needs_lock_chk: assert property (@(posedge clk_ref)
        tx_ready_o |-> (pll_lock_i && mclk_en_o && pd_pin_n && !cic_rst_o == !cic_rst_o));

    // R7
    pd_pin_gates_chk: assert property (@(posedge clk_ref)
        !pd_pin_n |-> (!tx_clk_en_o && cic_rst_o));

endmodule

// File: tb/txpd_sequencer_bench.sv
module txpd_sequencer_bench;
    logic       clk_ref = 1'b0;
    logic       rst_pin_n = 1'b0;
    logic       pd_pin_n = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic [7:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       wr_last_i = 1'b0;
    logic       mclk_en_o, tx_clk_en_o, cic_rst_o, regs_load_o, tx_ready_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk_ref = ~clk_ref;

    txpd_sequencer u_txpd_sequencer (
        .clk_ref     (clk_ref),
        .rst_pin_n   (rst_pin_n),
        .pd_pin_n    (pd_pin_n),
        .pll_lock_i  (pll_lock_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .wr_last_i   (wr_last_i),
        .mclk_en_o   (mclk_en_o),
        .tx_clk_en_o (tx_clk_en_o),
        .cic_rst_o   (cic_rst_o),
        .regs_load_o (regs_load_o),
        .tx_ready_o  (tx_ready_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk_ref);
        @(negedge clk_ref);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk_ref);
        wr_addr_i = a;
        wr_data_i = d;
        wr_last_i = 1'b1;
        @(posedge clk_ref);
        @(negedge clk_ref);
        wr_last_i = 1'b0;
    endtask

    task automatic t_reset_state();
        edges(20);
        chk("R2", "mclk in reset", mclk_en_o, 1'b0);
        chk("R2", "txclk in reset", tx_clk_en_o, 1'b0);
        chk("R2", "cic in reset", cic_rst_o, 1'b1);
        chk("R2", "ready in reset", tx_ready_o, 1'b0);
    endtask

    task automatic t_release();
        pd_pin_n  = 1'b1;
        pll_lock_i = 1'b1;
        rst_pin_n = 1'b1;
        edges(1);
        chk("R3", "mclk after edge 1", mclk_en_o, 1'b0);
        edges(1);
        chk("R4", "load pulse", regs_load_o, 1'b1);
        chk("R3", "mclk after edge 2", mclk_en_o, 1'b0);
        edges(1);
        chk("R4", "load pulse one cycle", regs_load_o, 1'b0);
        chk("R3", "mclk after edge 3", mclk_en_o, 1'b0);
        edges(1);
        chk("R3", "mclk after edge 4", mclk_en_o, 1'b1);
        chk("R10", "cic held after reset exit", cic_rst_o, 1'b1);
        edges(CIC_WAIT);
        chk("R10", "cic clear after hold", cic_rst_o, 1'b0);
        chk("R11", "ready when running", tx_ready_o, 1'b1);
    endtask

    localparam int CIC_WAIT = 90;

    task automatic t_glitch();
        @(negedge clk_ref);
        rst_pin_n = 1'b0;
        repeat (9) @(posedge clk_ref);
        @(negedge clk_ref);
        rst_pin_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            edges(1);
            chk("R1", "9-edge low ignored", mclk_en_o, 1'b1);
        end
        @(negedge clk_ref);
        rst_pin_n = 1'b0;
        repeat (10) @(posedge clk_ref);
        @(negedge clk_ref);
        rst_pin_n = 1'b1;
        edges(1);
        chk("R1", "10-edge low resets", mclk_en_o, 1'b0);
        chk("R2", "ready drops on reset", tx_ready_o, 1'b0);
        edges(4);
        chk("R3", "mclk back after reset", mclk_en_o, 1'b1);
        edges(CIC_WAIT);
    endtask

    task automatic t_pd_pin();
        @(negedge clk_ref);
        pd_pin_n = 1'b0;
        #1;
        chk("R7", "txclk off same cycle", tx_clk_en_o, 1'b0);
        chk("R7", "cic on same cycle", cic_rst_o, 1'b1);
        chk("R11", "ready off on pd", tx_ready_o, 1'b0);
        edges(5);
        pd_pin_n = 1'b1;
        #1;
        chk("R10", "txclk back at once", tx_clk_en_o, 1'b1);
        edges(79);
        chk("R10", "cic held cycle 80", cic_rst_o, 1'b1);
        edges(1);
        chk("R10", "cic released cycle 81", cic_rst_o, 1'b0);
    endtask

    task automatic t_sw_pd();
        reg_write(8'h03, 8'h20);
        chk("R8", "other address ignored", tx_clk_en_o, 1'b1);
        @(negedge clk_ref);
        wr_addr_i = 8'h02;
        wr_data_i = 8'h20;
        wr_last_i = 1'b1;
        #1;
        chk("R8", "no effect before edge", tx_clk_en_o, 1'b1);
        @(posedge clk_ref);
        @(negedge clk_ref);
        wr_last_i = 1'b0;
        chk("R8", "sw pd after edge", tx_clk_en_o, 1'b0);
        pd_pin_n = 1'b0;
        edges(3);
        pd_pin_n = 1'b1;
        edges(2);
        chk("R9", "sw pd still holds", tx_clk_en_o, 1'b0);
        chk("R9", "cic still held", cic_rst_o, 1'b1);
        reg_write(8'h02, 8'h00);
        chk("R9", "txclk after both released", tx_clk_en_o, 1'b1);
        edges(79);
        chk("R10", "cic held after sw release", cic_rst_o, 1'b1);
        edges(1);
        chk("R10", "cic free after sw release", cic_rst_o, 1'b0);
    endtask

    task automatic t_sw_reset();
        reg_write(8'h02, 8'h20);
        reg_write(8'h00, 8'h20);
        chk("R5", "mclk still on after write edge", mclk_en_o, 1'b1);
        edges(1);
        chk("R5", "mclk off after next edge", mclk_en_o, 1'b0);
        edges(1);
        chk("R4", "load pulse on sw reset", regs_load_o, 1'b1);
        edges(1);
        chk("R5", "mclk off before delay", mclk_en_o, 1'b0);
        edges(1);
        chk("R5", "mclk on four edges after write", mclk_en_o, 1'b1);
        chk("R4", "sw pd back to default", tx_clk_en_o, 1'b1);
        for (int i = 0; i < 10; i++) begin
            edges(1);
            chk("R6", "single sequence only", mclk_en_o, 1'b1);
        end
        edges(CIC_WAIT);
    endtask

    task automatic t_lock();
        @(negedge clk_ref);
        pll_lock_i = 1'b0;
        #1;
        chk("R11", "ready drops on lock loss", tx_ready_o, 1'b0);
        edges(2);
        pll_lock_i = 1'b1;
        #1;
        chk("R11", "ready back with lock", tx_ready_o, 1'b1);
    endtask

    initial begin
        t_reset_state();
        t_release();
        t_glitch();
        t_pd_pin();
        t_sw_pd();
        t_sw_reset();
        t_lock();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk_ref);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule